// File: doc/BRIEF.md
# Event Word-Stream Framer with CRC-16 Check Word

This block turns one trigger's worth of readout into a single framed event on a 16-bit valid/ready word stream. A one-cycle `start` pulse, given while the block is idle, captures seven header field values, a fixed number of trigger-summary words and the count of hit words that will follow. The block then emits the header, a length word, the hit words passed straight through from a valid/ready source, a separator, the trigger-summary words, a check word and an end marker. `out_last` flags the end marker.

The check word is a CRC-16 with polynomial 0x1021 and seed 0xFFFF. Each accepted word updates it, one whole word per clock, most significant bit first, with no reflection and no final inversion. It covers every word of the event before the check word. Back-pressure on `out_ready` can stall the stream at any word without changing the CRC. During the hit phase the hit source sees that back-pressure through `hit_ready`. The number of summary words and the width of the hit count are parameters.

Top module: `evt_framer`

## Requirements
- R1: After reset, `out_valid`, `out_last`, `hit_ready` and `busy` are all low.
- R2: The first seven words of an event are the header slots in slot order: slot k is `hdr_fields[16k+15:16k]`, slot 0 first. The slots are, in order, the token, the trigger word, the temperature, the firmware version, the hardware ID, the accelerator counter and the system status.
- R3: The eighth word is `hit_count`, zero-extended to 16 bits. After it come exactly `hit_count` words taken from `hit_data`, unchanged and in arrival order. `hit_ready` is high only during the hit phase, and then only while `out_ready` is high.
- R4: When `hit_count` is 0, the length word 0x0000 is followed directly by the separator.
- R5: The word after the last hit word is the separator 0xCCCC.
- R6: After the separator come N_TRIG trigger-summary words. Word j is `trig_info[16j+15:16j]`, captured at start, with slot 0 first.
- R7: The next word is the CRC-16 (polynomial 0x1021, seed 0xFFFF, MSB first, no reflection, no final XOR) computed over every earlier word of the same event.
- R8: The final word is 0xBBBB, and `out_last` is high only on that word. Once it is accepted, `busy` falls.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. Stalls of any length or pattern do not change the check word.
- R10: `start` is acted on only while `busy` is low. `busy` rises in the cycle after an accepted start. A start pulse, or changes on the field inputs, during an event leave that event's words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an event; captures the field inputs |
| hdr_fields | input | 112 | Seven 16-bit header slots, slot 0 in the low bits |
| trig_info | input | 16*N_TRIG | Trigger-summary slots, slot 0 in the low bits |
| hit_count | input | LEN_W | Number of hit words in this event |
| hit_data | input | 16 | Hit word from the source |
| hit_valid | input | 1 | Hit word present |
| hit_ready | output | 1 | Hit word taken this cycle when valid |
| out_data | output | 16 | Framed output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_last | output | 1 | Marks the end-marker word |
| busy | output | 1 | An event is in progress |

## Verification
The bench sweeps the hit count over 0, 1, 2, 3, 5, 9 and 17. For each count it combines four downstream ready patterns with three source-valid patterns and compares every word against an arithmetic model. The hit count of zero targets a framer that emits a phantom hit word or skips the separator. Stalls that land on the length, separator and check words catch a CRC that is updated on presented words rather than accepted ones; such a design corrupts the check word only under back-pressure. Some events carry a second start pulse and scrambled field inputs while they are in progress, to expose a design that re-captures fields mid-event or restarts its sequence.

// File: rtl/evt_pkg.sv
package evt_pkg;

   localparam int WORD_W    = 16;
   localparam int HDR_WORDS = 7;

   typedef logic [WORD_W-1:0] word_t;

   localparam word_t SEP_WORD = 16'hCCCC;
   localparam word_t END_WORD = 16'hBBBB;
   localparam word_t CRC_POLY = 16'h1021;
   localparam word_t CRC_SEED = 16'hFFFF;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_LEN,
      PH_HIT,
      PH_SEP,
      PH_TRIG,
      PH_CRC,
      PH_END
   } phase_e;

   // one whole data word folded into the CRC, MSB first
   function automatic word_t crc_word_step(input word_t crc, input word_t d, input word_t poly);
      word_t r;
      logic  fb;
      r = crc;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         fb = r[WORD_W-1] ^ d[i];
         r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return r;
   endfunction

endpackage

// File: rtl/evt_crc16.sv
module evt_crc16
   import evt_pkg::*;
#(
   parameter word_t POLY = CRC_POLY,
   parameter word_t SEED = CRC_SEED
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clear,
   input  logic  en,
   input  word_t din,
   output word_t crc
);

   always_ff @(posedge clk) begin
      if (!rst_n)     crc <= SEED;
      else if (clear) crc <= SEED;
      else if (en)    crc <= crc_word_step(crc, din, POLY);
   end

endmodule

// File: rtl/evt_seq.sv
module evt_seq
   import evt_pkg::*;
#(
   parameter int N_HDR  = HDR_WORDS,
   parameter int N_TRIG = 2,
   parameter int LEN_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [N_HDR*WORD_W-1:0]  hdr_flat,
   input  logic [N_TRIG*WORD_W-1:0] trig_flat,
   input  logic [LEN_W-1:0]         hit_count,
   input  word_t                    hit_data,
   input  logic                     hit_valid,
   output logic                     hit_ready,
   input  word_t                    crc_val,
   output word_t                    out_data,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic                     out_last,
   output logic                     busy,
   output logic                     crc_clear,
   output logic                     crc_en,
   output logic                     in_hit
);

   localparam int IDX_W  = (LEN_W > 8) ? LEN_W : 8;
   localparam int HSEL_W = (N_HDR > 1) ? $clog2(N_HDR) : 1;
   localparam int TSEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;

   phase_e             phase;
   logic [IDX_W-1:0]   idx;
   logic [LEN_W-1:0]   len_q;
   word_t              hdr_w  [N_HDR];
   word_t              trig_w [N_TRIG];
   word_t              hdr_q  [N_HDR];
   word_t              trig_q [N_TRIG];
   logic               fire;
   logic               take;

   for (genvar g = 0; g < N_HDR; g++) begin : g_hdr_unpack
      assign hdr_w[g] = hdr_flat[g*WORD_W +: WORD_W];
   end
   for (genvar g = 0; g < N_TRIG; g++) begin : g_trig_unpack
      assign trig_w[g] = trig_flat[g*WORD_W +: WORD_W];
   end

   assign take = start && (phase == PH_IDLE);

   always_comb begin
      out_data  = '0;
      out_valid = 1'b1;
      out_last  = 1'b0;
      unique case (phase)
         PH_IDLE: out_valid = 1'b0;
         PH_HDR:  out_data  = hdr_q[idx[HSEL_W-1:0]];
         PH_LEN:  out_data  = word_t'(len_q);
         PH_HIT: begin
            out_data  = hit_data;
            out_valid = hit_valid;
         end
         PH_SEP:  out_data  = SEP_WORD;
         PH_TRIG: out_data  = trig_q[idx[TSEL_W-1:0]];
         PH_CRC:  out_data  = crc_val;
         PH_END: begin
            out_data = END_WORD;
            out_last = 1'b1;
         end
         default: out_valid = 1'b0;
      endcase
   end

   assign fire      = out_valid && out_ready;
   assign in_hit    = (phase == PH_HIT);
   assign hit_ready = in_hit && out_ready;
   assign busy      = (phase != PH_IDLE);
   assign crc_clear = take;
   assign crc_en    = fire && (phase != PH_CRC) && (phase != PH_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         len_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (take) begin
               phase  <= PH_HDR;
               idx    <= '0;
               len_q  <= hit_count;
               hdr_q  <= hdr_w;
               trig_q <= trig_w;
            end
            PH_HDR: if (fire) begin
               if (idx == IDX_W'(N_HDR - 1)) begin
                  phase <= PH_LEN;
                  idx   <= '0;
               end else idx <= idx + 1'b1;
            end
            PH_LEN: if (fire) begin
               phase <= (len_q == '0) ? PH_SEP : PH_HIT;
               idx   <= '0;
            end
            PH_HIT: if (fire) begin
               if ((idx + 1'b1) == IDX_W'(len_q)) begin
                  phase <= PH_SEP;
                  idx   <= '0;
               end else idx <= idx + 1'b1;
            end
            PH_SEP: if (fire) begin
               phase <= PH_TRIG;
               idx   <= '0;
            end
            PH_TRIG: if (fire) begin
               if (idx == IDX_W'(N_TRIG - 1)) begin
                  phase <= PH_CRC;
                  idx   <= '0;
               end else idx <= idx + 1'b1;
            end
            PH_CRC: if (fire) phase <= PH_END;
            PH_END: if (fire) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/evt_framer.sv
module evt_framer
   import evt_pkg::*;
#(
   parameter int    N_TRIG = 2,
   parameter int    LEN_W  = 12,
   parameter word_t POLY   = CRC_POLY,
   parameter word_t SEED   = CRC_SEED
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [HDR_WORDS*WORD_W-1:0] hdr_fields,
   input  logic [N_TRIG*WORD_W-1:0]    trig_info,
   input  logic [LEN_W-1:0]            hit_count,
   input  logic [WORD_W-1:0]           hit_data,
   input  logic                        hit_valid,
   output logic                        hit_ready,
   output logic [WORD_W-1:0]           out_data,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic                        out_last,
   output logic                        busy
);

   if (N_TRIG < 1 || N_TRIG > 256) begin : g_bad_trig
      $error("evt_framer: N_TRIG must lie in 1..256");
   end
   if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
      $error("evt_framer: LEN_W must lie in 1..16");
   end

   word_t crc_val;
   logic  crc_clear;
   logic  crc_en;
   logic  in_hit;

   evt_seq #(
      .N_HDR (HDR_WORDS),
      .N_TRIG(N_TRIG),
      .LEN_W (LEN_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .hdr_flat (hdr_fields),
      .trig_flat(trig_info),
      .hit_count(hit_count),
      .hit_data (hit_data),
      .hit_valid(hit_valid),
      .hit_ready(hit_ready),
      .crc_val  (crc_val),
      .out_data (out_data),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_last (out_last),
      .busy     (busy),
      .crc_clear(crc_clear),
      .crc_en   (crc_en),
      .in_hit   (in_hit)
   );

   evt_crc16 #(
      .POLY(POLY),
      .SEED(SEED)
   ) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(crc_clear),
      .en   (crc_en),
      .din  (out_data),
      .crc  (crc_val)
   );

endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        out_valid,
   input logic        out_ready,
   input logic [15:0] out_data,
   input logic        out_last,
   input logic        hit_valid,
   input logic        hit_ready,
   input logic        in_hit
);

   // R1: nothing offered while no event is open
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !hit_ready && !out_last));

   // R3: the hit source is only drained while downstream accepts
   p_hit_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ready |-> (out_ready && in_hit));

   // R3: during the hit phase the output valid mirrors the source
   p_hit_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_hit |-> (out_valid == hit_valid));

   // R8: last flag only on the end marker
   p_last_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && out_data == 16'hBBBB));

   // R8: accepting the end marker closes the event
   p_last_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && out_ready) |=> !busy);

   // R9: framer-generated words hold under back-pressure
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !in_hit) |=> (out_valid && $stable(out_data)));

endmodule

bind evt_framer evt_framer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_last (out_last),
   .hit_valid(hit_valid),
   .hit_ready(hit_ready),
   .in_hit   (in_hit)
);

// File: tb/test_evt_framer.sv
module test_evt_framer;

   localparam int N_TRIG = 2;
   localparam int LEN_W  = 12;
   localparam int MAXW   = 64;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [7*16-1:0]       hdr_fields = '0;
   logic [N_TRIG*16-1:0]  trig_info = '0;
   logic [LEN_W-1:0]      hit_count = '0;
   logic [15:0]           hit_data = '0;
   logic                  hit_valid = 1'b0;
   logic                  hit_ready;
   logic [15:0]           out_data;
   logic                  out_valid;
   logic                  out_ready = 1'b0;
   logic                  out_last;
   logic                  busy;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   evt_framer #(.N_TRIG(N_TRIG), .LEN_W(LEN_W)) i_evt_framer (
      .clk(clk), .rst_n(rst_n), .start(start), .hdr_fields(hdr_fields),
      .trig_info(trig_info), .hit_count(hit_count), .hit_data(hit_data),
      .hit_valid(hit_valid), .hit_ready(hit_ready), .out_data(out_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
      .busy(busy)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
      logic [15:0] r;
      r = c ^ w;
      for (int b = 0; b < 16; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   function automatic bit ready_pat(input int m, input int c);
      case (m)
         0: return 1'b1;
         1: return (c % 2) == 1;
         2: return (c % 3) != 0;
         default: return ((c * 7 + 3) % 5) < 2;
      endcase
   endfunction

   function automatic bit valid_pat(input int m, input int c);
      case (m)
         0: return 1'b1;
         1: return (c % 2) == 0;
         default: return ((c * 5) % 7) > 2;
      endcase
   endfunction

   initial begin : watchdog
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   task automatic run_event(input int e, input int nh, input int rm, input int vm, input bit poke);
      logic [15:0] exp_w [MAXW];
      logic [15:0] hits  [MAXW];
      logic [15:0] crc;
      int n = 0;
      int k = 0;
      int hi = 0;
      int c = 0;
      bit hold = 0;
      bit stalled = 0;
      logic [15:0] stall_d = '0;
      string tag;

      for (int s = 0; s < 7; s++) begin
         hdr_fields[s*16 +: 16] = 16'((s + 1) * 16'h1111 ^ (e * 13));
         exp_w[n] = hdr_fields[s*16 +: 16];
         n++;
      end
      exp_w[n] = 16'(nh); n++;
      for (int i = 0; i < nh; i++) begin
         hits[i]  = 16'(e * 97 + i * 331 + 5);
         exp_w[n] = hits[i];
         n++;
      end
      exp_w[n] = 16'hCCCC; n++;
      for (int j = 0; j < N_TRIG; j++) begin
         trig_info[j*16 +: 16] = 16'(16'hA500 + j * 3 + e);
         exp_w[n] = trig_info[j*16 +: 16];
         n++;
      end
      crc = 16'hFFFF;
      for (int i = 0; i < n; i++) crc = ref_crc(crc, exp_w[i]);
      exp_w[n] = crc; n++;
      exp_w[n] = 16'hBBBB; n++;

      hit_count = LEN_W'(nh);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R10 busy after start", 16'(busy), 16'h1);
      if (poke) begin
         hdr_fields = ~hdr_fields;
         trig_info  = ~trig_info;
         hit_count  = ~hit_count;
      end

      while (k < n) begin
         if (c > 0) @(negedge clk);
         out_ready = ready_pat(rm, c);
         if (!hold) begin
            hit_valid = valid_pat(vm, c) && (hi < nh);
            hit_data  = (hi < nh) ? hits[hi] : 16'hDEAD;
         end
         start = poke && (c == 4);
         #1;
         if (stalled) check(out_valid === 1'b1 && out_data === stall_d,
                            "R9 held under stall", out_data, stall_d);
         stalled = out_valid && !out_ready;
         stall_d = out_data;
         if (out_valid && out_ready) begin
            if (k < 7)              tag = "R2 header";
            else if (k == 7)        tag = (nh == 0) ? "R4 zero length" : "R3 length";
            else if (k < 8 + nh)    tag = "R3 hit word";
            else if (k == 8 + nh)   tag = "R5 separator";
            else if (k < n - 2)     tag = "R6 trigger summary";
            else if (k == n - 2)    tag = "R7 crc";
            else                    tag = "R8 end marker";
            check(out_data === exp_w[k], tag, out_data, exp_w[k]);
            check(out_last === (k == n - 1), "R8 last flag", 16'(out_last), 16'(k == n - 1));
            k++;
         end
         if (hit_valid && hit_ready) hi++;
         hold = hit_valid && !hit_ready;
         c++;
      end
      @(negedge clk);
      start     = 1'b0;
      out_ready = 1'b0;
      hit_valid = 1'b0;
      #1;
      check(busy === 1'b0 && out_valid === 1'b0, "R8 idle after end", 16'(busy), 16'h0);
      check(hi == nh, "R3 hit count consumed", 16'(hi), 16'(nh));
   endtask

   initial begin : main
      int counts [7] = '{0, 1, 2, 3, 5, 9, 17};
      int e = 0;
      repeat (3) @(negedge clk);
      #1;
      check(out_valid === 1'b0 && out_last === 1'b0 && hit_ready === 1'b0 && busy === 1'b0,
            "R1 reset state", {12'h0, out_valid, out_last, hit_ready, busy}, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(busy === 1'b0 && out_valid === 1'b0, "R1 after release", 16'(busy), 16'h0);
      foreach (counts[ci]) begin
         for (int rm = 0; rm < 4; rm++) begin
            for (int vm = 0; vm < 3; vm++) begin
               run_event(e, counts[ci], rm, vm, (e % 3) == 1);
               e++;
            end
         end
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule